// File: doc/BRIEF.md
# Dual-Port Configuration Register File

This block is a small register file with two independent access ports. One port is an APB slave. The other port stands in for a serial configuration controller and is modelled as a parallel write strobe with a combinational read path. Each port has its own access rights for each register. The file holds several registers:

- two 32-bit general-purpose words, which take preset values from input pins while reset is held;
- an 8-bit register that drives eight indicator outputs;
- a register that samples eight switch inputs;
- a clock-lock status word, which combines eight lock inputs with an 8-bit enable mask into a single overall lock flag;
- two constant identification words.

The APB side completes every access with no wait states. When both ports write the same register in the same cycle, the APB write is kept.

Top module: `cfgreg_top`

## Requirements
- R1: While rst_n is low, USER0 and USER1 load preset_user[31:0] and preset_user[63:32]. The indicator register resets to 0x0F, the lock mask resets to 0xFF and the switch register resets to 0x00.
- R2: The indicator register is at offset 0x104 and reads back in bits [7:0]. Bit n drives led_out[n]. An APB write stores pwdata[7:0], so writing 0x03 drives only led_out[0] and led_out[1]. A configuration-port write to this offset has no effect.
- R3: The lock word at 0x100 reads the mask in [31:24], the raw lock_in in [23:16] and zeros in [15:1]. Only a configuration-port write changes the mask, taking cfg_wdata[31:24]. An APB write to 0x100 has no effect.
- R4: Bit 0 of the lock word is 1 exactly when every lock_in bit whose mask bit is 1 is high. With a zero mask it reads 1.
- R5: The switch register at 0x108 reads in bits [7:0] the value sw_in held three clock edges earlier (two synchronizer stages, then storage). Writes from either port have no effect.
- R6: Offset 0xFF8 reads {BUILD_NUM, 8'h00, 5'b0, 3'b111, 8'h02} from both ports. Writes there have no effect.
- R7: Offset 0xFFC reads {8'h41, VARIANT, 4'h0, 12'h224, REVISION} from both ports. Writes there have no effect.
- R8: USER0 (0x000) and USER1 (0x004) can be read and written from both ports. If both ports write the same word in one cycle, the APB data is stored. Writes to different words in one cycle both take effect.
- R9: An offset that is not listed, or that is not word aligned, reads zero on either port, and a write to it changes nothing.
- R10: pready is always 1 and pslverr is always 0. An APB write takes effect at the edge that ends its access phase. Read data follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| cfg_we | input | 1 | Configuration-port write strobe |
| cfg_addr | input | 12 | Configuration-port byte offset |
| cfg_wdata | input | 32 | Configuration-port write data |
| cfg_rdata | output | 32 | Configuration-port read data |
| preset_user | input | 64 | Preset words loaded into USER1:USER0 during reset |
| lock_in | input | 8 | Clock-lock inputs |
| sw_in | input | 8 | Switch inputs |
| led_out | output | 8 | Indicator outputs |

## Verification
A behavioural model predicts both read ports and the indicator outputs on every clock. These predictions are checked against the directed expectations below.

Ownership is tested by writing each register from the port that owns it and from the port that does not. This separates the owner's write from an ignored write.

Same-cycle writes are tried on the same word and on different words. This shows APB priority apart from simple merging of the two writes.

The lock flag is tried with several mask and lock patterns: full mask, partial mask, zero mask, and lock bits that lie only outside the mask. These patterns show masking apart from a plain AND of the inputs.

A switch step is sampled after one, two and three edges to pin down the pipeline depth. Misaligned and unlisted offsets show that decoding is exact.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int DW       = 32;
  localparam int AW       = 12;
  localparam int WW       = AW - 2;
  localparam int NUM_USER = 2;
  localparam int LED_N    = 8;
  localparam int SW_N     = 8;
  localparam int LOCK_N   = 8;

  localparam logic [WW-1:0] W_LOCK = 10'h040;
  localparam logic [WW-1:0] W_LED  = 10'h041;
  localparam logic [WW-1:0] W_SW   = 10'h042;
  localparam logic [WW-1:0] W_AID  = 10'h3FE;
  localparam logic [WW-1:0] W_ID   = 10'h3FF;

  // overall lock: every enabled input must be high
  function automatic logic lock_all(input logic [LOCK_N-1:0] mask,
                                    input logic [LOCK_N-1:0] lk);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LOCK_N; i++)
      if (mask[i] && !lk[i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [DW-1:0] pack_lock(input logic [LOCK_N-1:0] mask,
                                              input logic [LOCK_N-1:0] lk,
                                              input logic locked);
    return {mask, lk, 15'd0, locked};
  endfunction

  function automatic logic [DW-1:0] make_aid(input logic [7:0] build);
    return {build, 8'h00, 5'b00000, 3'b111, 8'(NUM_USER)};
  endfunction

  function automatic logic [DW-1:0] make_id(input logic [3:0] variant,
                                            input logic [3:0] rev);
    return {8'h41, variant, 4'h0, 12'h224, rev};
  endfunction

  function automatic logic aligned(input logic [AW-1:0] a);
    return (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/cfgreg_sync.sv
module cfgreg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgreg_lock.sv
module cfgreg_lock
  import cfgreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_mask,
  input  logic [LOCK_N-1:0] mask_wdata,
  input  logic [LOCK_N-1:0] lock_in,
  output logic [DW-1:0]     status,
  output logic              locked
);
  logic [LOCK_N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_q <= '1;
    else if (cfg_wr_mask) mask_q <= mask_wdata;
  end

  assign locked = lock_all(mask_q, lock_in);
  assign status = pack_lock(mask_q, lock_in, locked);

  // R3: mask moves only on a configuration-port write
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_mask |=> $stable(mask_q));
  // R4: all inputs high always reads locked
  a_r4_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    (&lock_in) |-> locked);
  // R4: with a full mask, any low input clears the flag
  a_r4_full_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_q) && !(&lock_in)) |-> !locked);
endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
  import cfgreg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_USER*DW-1:0]        preset_user,
  input  logic [DW-1:0]                 apb_wdata,
  input  logic [DW-1:0]                 cfg_wdata,
  input  logic [NUM_USER-1:0]           apb_wr_user,
  input  logic [NUM_USER-1:0]           cfg_wr_user,
  input  logic                          apb_wr_led,
  input  logic [SW_N-1:0]               sw_sync,
  output logic [NUM_USER-1:0][DW-1:0]   user_q,
  output logic [LED_N-1:0]              led_q,
  output logic [SW_N-1:0]               sw_q
);
  for (genvar i = 0; i < NUM_USER; i++) begin : g_user
    always_ff @(posedge clk) begin
      if (!rst_n)              user_q[i] <= preset_user[i*DW +: DW];
      else if (apb_wr_user[i]) user_q[i] <= apb_wdata;
      else if (cfg_wr_user[i]) user_q[i] <= cfg_wdata;
    end

    // R8: on a same-cycle collision the APB data is kept
    a_r8_apb_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (apb_wr_user[i] && cfg_wr_user[i]) |=> (user_q[i] == $past(apb_wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= 8'h0F;
      sw_q  <= '0;
    end else begin
      if (apb_wr_led) led_q <= apb_wdata[LED_N-1:0];
      sw_q <= sw_sync;
    end
  end

  // R2: indicators change only on an APB write to their offset
  a_r2_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apb_wr_led |=> $stable(led_q));
endmodule

// File: rtl/cfgreg_top.sv
module cfgreg_top
  import cfgreg_pkg::*;
#(
  parameter logic [7:0] BUILD_NUM = 8'h01,
  parameter logic [3:0] VARIANT   = 4'h0,
  parameter logic [3:0] REVISION  = 4'h1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [AW-1:0]          paddr,
  input  logic [DW-1:0]          pwdata,
  output logic [DW-1:0]          prdata,
  output logic                   pready,
  output logic                   pslverr,
  input  logic                   cfg_we,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata,
  input  logic [NUM_USER*DW-1:0] preset_user,
  input  logic [LOCK_N-1:0]      lock_in,
  input  logic [SW_N-1:0]        sw_in,
  output logic [LED_N-1:0]       led_out
);
  localparam logic [DW-1:0] AID_WORD = make_aid(BUILD_NUM);
  localparam logic [DW-1:0] ID_WORD  = make_id(VARIANT, REVISION);

  logic [WW-1:0] apb_w, cfg_w;
  logic apb_ok, cfg_ok, apb_wr, cfg_wr;
  logic [NUM_USER-1:0] apb_wr_user, cfg_wr_user;
  logic apb_wr_led, cfg_wr_mask;
  logic [NUM_USER-1:0][DW-1:0] user_q;
  logic [LED_N-1:0] led_q;
  logic [SW_N-1:0]  sw_sync, sw_q;
  logic [DW-1:0]    lock_word;
  logic             locked;
  logic             apb_known;

  assign apb_w  = paddr[AW-1:2];
  assign cfg_w  = cfg_addr[AW-1:2];
  assign apb_ok = aligned(paddr);
  assign cfg_ok = aligned(cfg_addr);
  assign apb_wr = psel && penable && pwrite && apb_ok;
  assign cfg_wr = cfg_we && cfg_ok;

  for (genvar i = 0; i < NUM_USER; i++) begin : g_dec
    assign apb_wr_user[i] = apb_wr && (apb_w == WW'(i));
    assign cfg_wr_user[i] = cfg_wr && (cfg_w == WW'(i));
  end
  assign apb_wr_led  = apb_wr && (apb_w == W_LED);
  assign cfg_wr_mask = cfg_wr && (cfg_w == W_LOCK);

  cfgreg_sync #(.W(SW_N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_in), .q(sw_sync)
  );

  cfgreg_store u_store (
    .clk(clk), .rst_n(rst_n), .preset_user(preset_user),
    .apb_wdata(pwdata), .cfg_wdata(cfg_wdata),
    .apb_wr_user(apb_wr_user), .cfg_wr_user(cfg_wr_user),
    .apb_wr_led(apb_wr_led), .sw_sync(sw_sync),
    .user_q(user_q), .led_q(led_q), .sw_q(sw_q)
  );

  cfgreg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .cfg_wr_mask(cfg_wr_mask),
    .mask_wdata(cfg_wdata[DW-1 -: LOCK_N]), .lock_in(lock_in),
    .status(lock_word), .locked(locked)
  );

  function automatic logic [DW-1:0] pick(input logic ok, input logic [WW-1:0] w,
                                         input logic [NUM_USER-1:0][DW-1:0] u,
                                         input logic [DW-1:0] lw,
                                         input logic [LED_N-1:0] ld,
                                         input logic [SW_N-1:0] sw);
    logic [DW-1:0] r;
    r = '0;
    if (ok) begin
      for (int i = 0; i < NUM_USER; i++)
        if (w == WW'(i)) r = u[i];
      case (w)
        W_LOCK:  r = lw;
        W_LED:   r = DW'(ld);
        W_SW:    r = DW'(sw);
        W_AID:   r = AID_WORD;
        W_ID:    r = ID_WORD;
        default: ;
      endcase
    end
    return r;
  endfunction

  assign prdata    = pick(apb_ok, apb_w, user_q, lock_word, led_q, sw_q);
  assign cfg_rdata = pick(cfg_ok, cfg_w, user_q, lock_word, led_q, sw_q);
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign led_out   = led_q;

  assign apb_known = apb_ok && ((apb_w < WW'(NUM_USER)) || apb_w == W_LOCK ||
                     apb_w == W_LED || apb_w == W_SW || apb_w == W_AID || apb_w == W_ID);

  // R9: unlisted or misaligned offsets read zero
  a_r9_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !apb_known) |-> (prdata == '0));
  // R4: the flag seen on the read port tracks the lock module
  a_r4_flag_port: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && apb_ok && apb_w == W_LOCK) |-> (prdata[0] == locked));
endmodule

// File: tb/sim_cfgreg_top.sv
module sim_cfgreg_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic cfg_we = 0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] preset_user = {32'h5A5A_0002, 32'hA5A5_0001};
  logic [7:0] lock_in = 8'hFF;
  logic [7:0] sw_in = 8'h00;
  logic [7:0] led_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgreg_top u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .preset_user(preset_user),
    .lock_in(lock_in), .sw_in(sw_in), .led_out(led_out)
  );

  // behavioural reference
  logic [31:0] m_user [2];
  logic [7:0]  m_led, m_mask, m_sw;
  logic [7:0]  sw_pipe [$];

  function automatic string tag_of(input logic [11:0] a);
    if (a[1:0] != 2'b00) return "R9";
    case (a)
      12'h000, 12'h004: return "R8";
      12'h100: return "R3/R4";
      12'h104: return "R2";
      12'h108: return "R5";
      12'hFF8: return "R6";
      12'hFFC: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic flag;
    flag = 1'b1;
    for (int i = 0; i < 8; i++) if (m_mask[i] == 1'b1 && lock_in[i] == 1'b0) flag = 1'b0;
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      12'h000: return m_user[0];
      12'h004: return m_user[1];
      12'h100: return {m_mask, lock_in, 16'h0} | {31'h0, flag};
      12'h104: return {24'h0, m_led};
      12'h108: return {24'h0, m_sw};
      12'hFF8: return 32'h0100_0702;
      12'hFFC: return 32'h4100_2241;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_user[0] = preset_user[31:0];
      m_user[1] = preset_user[63:32];
      m_led = 8'h0F; m_mask = 8'hFF; m_sw = 8'h00;
      sw_pipe = '{8'h00, 8'h00};
    end else begin
      sw_pipe.push_back(sw_in);
      m_sw = sw_pipe.pop_front();
      if (cfg_we && cfg_addr == 12'h100) m_mask = cfg_wdata[31:24];
      if (psel && penable && pwrite && paddr == 12'h104) m_led = pwdata[7:0];
      for (int i = 0; i < 2; i++) begin
        if (psel && penable && pwrite && paddr == 12'(i*4)) m_user[i] = pwdata;
        else if (cfg_we && cfg_addr == 12'(i*4)) m_user[i] = cfg_wdata;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(tag_of(paddr), prdata, model_read(paddr));
      chk(tag_of(cfg_addr), cfg_rdata, model_read(cfg_addr));
      chk("R2", {24'h0, led_out}, {24'h0, m_led});
      chk("R10", {30'h0, pready, pslverr}, 32'h2);
    end
  end

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    #1;
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    #1;
  endtask

  task automatic both_write(input logic [11:0] aa, input logic [31:0] ad,
                            input logic [11:0] ca, input logic [31:0] cd);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = aa; pwdata = ad;
    @(negedge clk); penable = 1; cfg_we = 1; cfg_addr = ca; cfg_wdata = cd;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; cfg_we = 0;
    #1;
  endtask

  task automatic look(input logic [11:0] a);
    @(negedge clk); paddr = a; cfg_addr = a;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1", {24'h0, led_out}, 32'h0000_000F);
    look(12'h000); chk("R1", prdata, 32'hA5A5_0001);
    look(12'h004); chk("R1", cfg_rdata, 32'h5A5A_0002);
    look(12'h100); chk("R1", {24'h0, prdata[31:24]}, 32'hFF);
    look(12'h108); chk("R1", prdata, 32'h0);
    chk("R10", {31'h0, pready}, 32'h1);
    // R2: owner write, then ignored config write
    apb_write(12'h104, 32'hFFFF_FF03);
    chk("R2", {24'h0, led_out}, 32'h03);
    cfg_write(12'h104, 32'h0000_00AA);
    chk("R2", {24'h0, led_out}, 32'h03);
    // R8: both ports write user words
    apb_write(12'h000, 32'h1234_5678);
    cfg_write(12'h004, 32'hCAFE_F00D);
    look(12'h000); chk("R8", cfg_rdata, 32'h1234_5678);
    look(12'h004); chk("R8", prdata, 32'hCAFE_F00D);
    both_write(12'h000, 32'h1111_1111, 12'h000, 32'h2222_2222);
    look(12'h000); chk("R8", prdata, 32'h1111_1111);
    both_write(12'h004, 32'h3333_3333, 12'h000, 32'h4444_4444);
    look(12'h000); chk("R8", prdata, 32'h4444_4444);
    look(12'h004); chk("R8", prdata, 32'h3333_3333);
    // R3: mask ownership
    apb_write(12'h100, 32'h0000_0000);
    look(12'h100); chk("R3", {24'h0, prdata[31:24]}, 32'hFF);
    cfg_write(12'h100, 32'h0F00_0000);
    look(12'h100); chk("R3", {24'h0, prdata[31:24]}, 32'h0F);
    // R4: lock patterns
    @(negedge clk); lock_in = 8'h0F; #1; chk("R4", {31'h0, prdata[0]}, 32'h1);
    chk("R3", {24'h0, prdata[23:16]}, 32'h0F);
    @(negedge clk); lock_in = 8'hF0; #1; chk("R4", {31'h0, prdata[0]}, 32'h0);
    @(negedge clk); lock_in = 8'h1F; #1; chk("R4", {31'h0, prdata[0]}, 32'h1);
    cfg_write(12'h100, 32'h0000_0000);
    @(negedge clk); lock_in = 8'h00; #1; chk("R4", {31'h0, prdata[0]}, 32'h1);
    cfg_write(12'h100, 32'hFF00_0000);
    @(negedge clk); lock_in = 8'hFE; #1; chk("R4", {31'h0, prdata[0]}, 32'h0);
    chk("R3", {16'h0, prdata[15:0]}, 32'h0);
    // R5: switch pipeline depth
    look(12'h108);
    @(negedge clk); sw_in = 8'h5C;
    @(negedge clk); #1; chk("R5", prdata, 32'h00);
    @(negedge clk); #1; chk("R5", prdata, 32'h00);
    @(negedge clk); #1; chk("R5", prdata, 32'h5C);
    apb_write(12'h108, 32'h0000_00FF);
    cfg_write(12'h108, 32'h0000_00FF);
    look(12'h108); chk("R5", prdata, 32'h5C);
    // R6 / R7: identification, writes ignored
    apb_write(12'hFF8, 32'h0);
    cfg_write(12'hFFC, 32'h0);
    look(12'hFF8); chk("R6", prdata, 32'h0100_0702); chk("R6", cfg_rdata, 32'h0100_0702);
    look(12'hFFC); chk("R7", prdata, 32'h4100_2241); chk("R7", cfg_rdata, 32'h4100_2241);
    // R9: undefined and misaligned offsets
    look(12'h008); chk("R9", prdata, 32'h0); chk("R9", cfg_rdata, 32'h0);
    look(12'h200); chk("R9", prdata, 32'h0);
    look(12'hFF4); chk("R9", cfg_rdata, 32'h0);
    look(12'h001); chk("R9", prdata, 32'h0);
    apb_write(12'h002, 32'hDEAD_BEEF);
    cfg_write(12'h005, 32'hDEAD_BEEF);
    look(12'h000); chk("R9", prdata, 32'h4444_4444);
    look(12'h004); chk("R9", prdata, 32'h3333_3333);
    apb_write(12'h106, 32'h0000_0000);
    chk("R9", {24'h0, led_out}, 32'h03);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule